// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This unit carries out the rotate-right instructions of a 64-bit integer pipeline within a single combinational evaluation. It takes a 32-bit instruction word, the operand to rotate and the value of the register that supplies a variable amount. It returns the 64-bit destination value and a flag that is high only when the word is one of the five rotate forms.

The unit sits next to the logical shifter, which uses the same opcode space. The two are told apart by a five-bit marker. An immediate form has the marker in the register-select field at bits 25:21 and reads the amount from bits 10:6. A variable form has the marker in the amount field at bits 10:6 and reads the amount from the register value.

Word (32-bit) forms rotate the low half of the operand and sign-extend the result. Doubleword forms rotate all 64 bits. One doubleword immediate form adds 32 to its five-bit amount, which gives rotates of 32 to 63.

The style has no states to name, because the unit holds none. The decoder sorts each word into one of six kinds instead:

- KIND_NONE: not a rotate.
- KIND_W_IMM: word rotate, immediate amount.
- KIND_D_IMM: doubleword rotate, immediate amount.
- KIND_D_HI_IMM: doubleword rotate, immediate amount plus 32.
- KIND_W_VAR: word rotate, amount from the register.
- KIND_D_VAR: doubleword rotate, amount from the register.

Top module: `rotu_exec`

## Requirements
- R1: `rot_valid` is high only when bits 31:26 are 000000 and the word matches one of the five rotate forms. For any other word `rot_valid` is low, and `rot_result` is then don't-care.
- R2: Immediate word rotate. Bits 25:21 are 00001 and bits 5:0 are 000010. The low 32 bits of `src_val` are rotated right by the amount in bits 10:6.
- R3: Immediate doubleword rotate. Bits 25:21 are 00001 and bits 5:0 are 111010. All 64 bits of `src_val` are rotated right by the amount in bits 10:6.
- R4: Upper-half doubleword rotate. Bits 25:21 are 00001 and bits 5:0 are 111110. `src_val` is rotated right by 32 plus the amount in bits 10:6.
- R5: Variable word rotate. Bits 10:6 are 00001 and bits 5:0 are 000110. The amount is bits 4:0 of `amt_val`, and the higher bits of `amt_val` have no effect.
- R6: Variable doubleword rotate. Bits 10:6 are 00001 and bits 5:0 are 010110. The amount is bits 5:0 of `amt_val`, and the higher bits have no effect.
- R7: Logical shift words are reported as not rotates. These are words with 00000 in the marker field: bits 25:21 for the immediate function codes and bits 10:6 for the variable function codes.
- R8: For word rotates, bits 63:32 of `src_val` have no effect on `rot_result`.
- R9: A word whose bits 31:26 are not 000000 is never a rotate, even if every other field matches.
- R10: For word rotates, bits 63:32 of `rot_result` all equal bit 31 of the rotated 32-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| src_val | input | 64 | Operand to be rotated |
| amt_val | input | 64 | Register value that gives the amount for variable forms |
| rot_result | output | 64 | Destination value |
| rot_valid | output | 1 | High when `instr` is a rotate form |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath and a 32-bit word half. Both rotator instances therefore have their full stage counts of six and five. The chosen amounts reach the end of every stage, including 0, 31, 32 and 63, and the upper-half form covers the edges of its 32 to 63 range. Operands with set upper halves and amount registers with high bits set show that the word forms ignore those bits and still sign-extend from the correct bit.

// File: rtl/rotu_pkg.sv
package rotu_pkg;

    localparam logic [5:0] OPC_SPECIAL = 6'b000000;
    localparam logic [4:0] ROT_MARK    = 5'b00001;

    localparam logic [5:0] FN_W_IMM    = 6'b000010;
    localparam logic [5:0] FN_D_IMM    = 6'b111010;
    localparam logic [5:0] FN_D_HI_IMM = 6'b111110;
    localparam logic [5:0] FN_W_VAR    = 6'b000110;
    localparam logic [5:0] FN_D_VAR    = 6'b010110;

    typedef enum logic [2:0] {
        KIND_NONE     = 3'd0,
        KIND_W_IMM    = 3'd1,
        KIND_D_IMM    = 3'd2,
        KIND_D_HI_IMM = 3'd3,
        KIND_W_VAR    = 3'd4,
        KIND_D_VAR    = 3'd5
    } rot_kind_e;

endpackage

// File: rtl/rotu_decode.sv
module rotu_decode
    import rotu_pkg::*;
#(
    parameter int DW = 64,
    localparam int AW = $clog2(DW)
) (
    input  logic [31:0]   instr,
    input  logic [DW-1:0] amt_val,
    output rot_kind_e     kind,
    output logic [AW-1:0] amount,
    output logic          is_word
);

    logic [5:0] opc;
    logic [4:0] sel_field;
    logic [4:0] sa_field;
    logic [5:0] fn;

    assign opc       = instr[31:26];
    assign sel_field = instr[25:21];
    assign sa_field  = instr[10:6];
    assign fn        = instr[5:0];

    always_comb begin
        kind = KIND_NONE;
        if (opc == OPC_SPECIAL) begin
            unique case (fn)
                FN_W_IMM:    if (sel_field == ROT_MARK) kind = KIND_W_IMM;
                FN_D_IMM:    if (sel_field == ROT_MARK) kind = KIND_D_IMM;
                FN_D_HI_IMM: if (sel_field == ROT_MARK) kind = KIND_D_HI_IMM;
                FN_W_VAR:    if (sa_field  == ROT_MARK) kind = KIND_W_VAR;
                FN_D_VAR:    if (sa_field  == ROT_MARK) kind = KIND_D_VAR;
                default:     kind = KIND_NONE;
            endcase
        end
    end

    always_comb begin
        amount = '0;
        unique case (kind)
            KIND_W_IMM, KIND_D_IMM: amount = AW'(sa_field);
            KIND_D_HI_IMM:          amount = AW'({1'b1, sa_field});
            KIND_W_VAR:             amount = AW'(amt_val[4:0]);
            KIND_D_VAR:             amount = amt_val[AW-1:0];
            default:                amount = '0;
        endcase
    end

    assign is_word = (kind == KIND_W_IMM) || (kind == KIND_W_VAR);

    always_comb begin
        // R9
        if (kind != KIND_NONE) begin
            opcode_gate_chk: assert (opc == OPC_SPECIAL)
                else $error("rotate decoded under a nonzero opcode");
        end
        // R4
        if (kind == KIND_D_HI_IMM) begin
            hi_half_amount_chk: assert (amount >= AW'(32))
                else $error("upper-half rotate amount below 32");
        end
    end

endmodule

// File: rtl/rotu_rotr.sv
module rotu_rotr #(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stage [SW+1];

    assign stage[0] = din;

    generate
        for (genvar s = 0; s < SW; s++) begin : g_stage
            localparam int SH = 1 << s;
            assign stage[s+1] = amt[s] ? {stage[s][SH-1:0], stage[s][W-1:SH]}
                                       : stage[s];
        end
    endgenerate

    assign dout = stage[SW];

    always_comb begin
        // R3
        ones_keep_chk: assert ($countones(dout) == $countones(din))
            else $error("rotate changed the population count");
        // R2
        if (amt == '0) begin
            zero_amt_chk: assert (dout == din)
                else $error("zero-amount rotate changed the data");
        end
    end

endmodule

// File: rtl/rotu_exec.sv
module rotu_exec
    import rotu_pkg::*;
#(
    parameter int DW = 64,
    parameter int HW = 32,
    localparam int AW = $clog2(DW),
    localparam int HAW = $clog2(HW)
) (
    input  logic [31:0]   instr,
    input  logic [DW-1:0] src_val,
    input  logic [DW-1:0] amt_val,
    output logic [DW-1:0] rot_result,
    output logic          rot_valid
);

    rot_kind_e     kind;
    logic [AW-1:0] amount;
    logic          is_word;
    logic [DW-1:0] dword_rot;
    logic [HW-1:0] word_rot;

    rotu_decode #(.DW(DW)) u_decode (
        .instr   (instr),
        .amt_val (amt_val),
        .kind    (kind),
        .amount  (amount),
        .is_word (is_word)
    );

    rotu_rotr #(.W(DW)) u_rot_dword (
        .din  (src_val),
        .amt  (amount),
        .dout (dword_rot)
    );

    rotu_rotr #(.W(HW)) u_rot_word (
        .din  (src_val[HW-1:0]),
        .amt  (amount[HAW-1:0]),
        .dout (word_rot)
    );

    assign rot_valid  = (kind != KIND_NONE);
    assign rot_result = is_word ? {{(DW-HW){word_rot[HW-1]}}, word_rot} : dword_rot;

    always_comb begin
        // R10
        if (rot_valid && is_word) begin
            word_sext_chk: assert (rot_result[DW-1:HW] == {(DW-HW){rot_result[HW-1]}})
                else $error("word rotate not sign-extended");
        end
        // R1
        if (rot_valid) begin
            valid_opc_chk: assert (instr[31:26] == 6'b000000)
                else $error("valid raised for a foreign opcode");
        end
        // R8
        if (rot_valid && is_word) begin
            word_ones_chk: assert ($countones(rot_result[HW-1:0]) == $countones(src_val[HW-1:0]))
                else $error("word rotate lost bits of the low half");
        end
    end

endmodule

// File: tb/test_rotu_exec.sv
module test_rotu_exec;

    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [63:0] src_val;
    logic [63:0] amt_val;
    logic [63:0] rot_result;
    logic        rot_valid;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always #5 clk = ~clk;

    rotu_exec i_rotu_exec (
        .instr      (instr),
        .src_val    (src_val),
        .amt_val    (amt_val),
        .rot_result (rot_result),
        .rot_valid  (rot_valid)
    );

    function automatic logic [63:0] ref_w(input logic [63:0] x, input int n);
        logic [63:0] dbl;
        logic [31:0] r;
        dbl = {x[31:0], x[31:0]} >> n;
        r = dbl[31:0];
        return {{32{r[31]}}, r};
    endfunction

    function automatic logic [63:0] ref_d(input logic [63:0] x, input int n);
        logic [127:0] dbl;
        dbl = {x, x} >> n;
        return dbl[63:0];
    endfunction

    function automatic logic [31:0] enc_imm(input logic [4:0] mark, input logic [4:0] sa,
                                            input logic [5:0] fn);
        return {6'b000000, mark, 5'd3, 5'd4, sa, fn};
    endfunction

    function automatic logic [31:0] enc_var(input logic [4:0] mark, input logic [5:0] fn);
        return {6'b000000, 5'd5, 5'd3, 5'd4, mark, fn};
    endfunction

    task automatic apply(input logic [31:0] w, input logic [63:0] s, input logic [63:0] a);
        @(negedge clk);
        instr = w;
        src_val = s;
        amt_val = a;
        #2;
    endtask

    task automatic chk_val(input string req, input logic exp);
        n_checks++;
        if (rot_valid !== exp) begin
            n_fail++;
            $display("FAIL %s valid: actual %b expected %b", req, rot_valid, exp);
        end
    endtask

    task automatic chk_res(input string req, input logic [63:0] exp);
        n_checks++;
        if (rot_valid !== 1'b1 || rot_result !== exp) begin
            n_fail++;
            $display("FAIL %s result: actual %h/%b expected %h/1", req, rot_result, rot_valid, exp);
        end
    endtask

    task automatic t_idle;
        apply(32'h0, 64'h0123_4567_89AB_CDEF, 64'h0);
        chk_val("R1", 1'b0);
    endtask

    task automatic t_w_imm;
        logic [63:0] s = 64'hDEAD_BEEF_1234_5678;
        int amts[4] = '{0, 1, 16, 31};
        foreach (amts[i]) begin
            apply(enc_imm(5'b00001, amts[i][4:0], 6'b000010), s, 64'h0);
            chk_res("R2", ref_w(s, amts[i]));
        end
        apply(enc_imm(5'b00001, 5'd4, 6'b000010), 64'h0000_0000_0000_0008, 64'h0);
        chk_res("R10", 64'hFFFF_FFFF_8000_0000);
        apply(enc_imm(5'b00001, 5'd4, 6'b000010), 64'hFFFF_FFFF_0000_0008, 64'h0);
        chk_res("R8", 64'hFFFF_FFFF_8000_0000);
    endtask

    task automatic t_d_imm;
        logic [63:0] s = 64'h8000_0000_0000_0F01;
        int amts[3] = '{0, 9, 31};
        foreach (amts[i]) begin
            apply(enc_imm(5'b00001, amts[i][4:0], 6'b111010), s, 64'h0);
            chk_res("R3", ref_d(s, amts[i]));
        end
    endtask

    task automatic t_d_hi;
        logic [63:0] s = 64'hA5A5_0000_1234_FFFF;
        apply(enc_imm(5'b00001, 5'd0, 6'b111110), s, 64'h0);
        chk_res("R4", ref_d(s, 32));
        apply(enc_imm(5'b00001, 5'd31, 6'b111110), s, 64'h0);
        chk_res("R4", ref_d(s, 63));
    endtask

    task automatic t_w_var;
        logic [63:0] s = 64'h1111_2222_0000_00F3;
        apply(enc_var(5'b00001, 6'b000110), s, 64'hFFFF_FFFF_FFFF_FFE5);
        chk_res("R5", ref_w(s, 5));
        apply(enc_var(5'b00001, 6'b000110), s, 64'h0000_0000_0000_0020);
        chk_res("R5", ref_w(s, 0));
    endtask

    task automatic t_d_var;
        logic [63:0] s = 64'hF00D_CAFE_0000_0001;
        apply(enc_var(5'b00001, 6'b010110), s, 64'h8000_0000_0000_0047);
        chk_res("R6", ref_d(s, 7));
        apply(enc_var(5'b00001, 6'b010110), s, 64'h0000_0000_0000_003F);
        chk_res("R6", ref_d(s, 63));
    endtask

    task automatic t_logical;
        apply(enc_imm(5'b00000, 5'd3, 6'b000010), 64'h5, 64'h0);
        chk_val("R7", 1'b0);
        apply(enc_var(5'b00000, 6'b000110), 64'h5, 64'h3);
        chk_val("R7", 1'b0);
        apply(enc_imm(5'b00000, 5'd3, 6'b111110), 64'h5, 64'h0);
        chk_val("R7", 1'b0);
    endtask

    task automatic t_foreign;
        logic [31:0] w;
        w = enc_imm(5'b00001, 5'd3, 6'b111010);
        w[31:26] = 6'b011100;
        apply(w, 64'h5, 64'h0);
        chk_val("R9", 1'b0);
        apply(enc_imm(5'b00010, 5'd3, 6'b111010), 64'h5, 64'h0);
        chk_val("R1", 1'b0);
        apply(enc_var(5'b00001, 6'b000111), 64'h5, 64'h1);
        chk_val("R1", 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        instr = 32'h0;
        src_val = 64'h0;
        amt_val = 64'h0;
        t_idle();
        t_w_imm();
        t_d_imm();
        t_d_hi();
        t_w_var();
        t_d_var();
        t_logical();
        t_foreign();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule